// File: doc/BRIEF.md
# Biased Random Pattern Register

This block is a reconfigurable test register that, besides working as an ordinary parallel-load register, can produce pseudo-random test patterns whose bits are one with a chosen probability in steps of one eighth. It can also compress responses into a signature and act as a plain serial shift chain. All of its storage is in two chained sections. The first is a short linear feedback section whose stages use internal XOR feedback. The second is a shift section fed by a three-input Boolean function of chosen bits of the first section.

Pattern generation needs a random bit stream at the serial input, such as a longer maximal-length LFSR or the serial output of another instance. The feedback section spreads that stream across its stages, so at any time the stages are uniform and independent. The three-input function turns three of them into one bit with probability p = (number of ones in its truth table)/8. The shift section carries that biased bit down the chain, inverting it at chosen stages, so each stage holds a bit with probability p or 1-p. The polynomial, the taps, the truth table and the inversion mask are compile-time parameters. The first feedback-section stage must be a feedback cell (bit 0 of the feedback mask set).

Top module: `biased_pattern_reg`

## Requirements
- R1: While the active-low asynchronous reset is low, every stage is zero, so `q` and `serialOut` read zero.
- R2: With mode 2'b11 (load), each clock edge copies `dIn` into the stages, and `q` equals the loaded value after the edge.
- R3: With mode 2'b01 (shift), stage 0 takes `serialIn` and every other stage takes the stage below it, with no inversion and no feedback.
- R4: With mode 2'b00 (generate), feedback-section stage 0 takes `serialIn` XOR the top feedback-section stage. Stage i>0 takes stage i-1, XORed with that top stage when bit i of FB_MASK is set.
- R5: In generate mode, shift-section stage 0 takes F_TABLE indexed by {lr[TAP2], lr[TAP1], lr[TAP0]}, inverted when bit 0 of INV_MASK is set.
- R6: In generate mode, shift-section stage j>0 takes stage j-1, inverted when bit j of INV_MASK is set.
- R7: Under a random `serialIn` stream in generate mode, the fraction of ones at each shift-section stage is p, or 1-p when the XOR of INV_MASK bits 0..j is one, where p is the count of ones in F_TABLE over 8.
- R8: With mode 2'b10 (signature), the two sections form one multiple-input signature register. The feedback taps take the top shift-section stage instead of the top feedback-section stage. Stage 0 also XORs in `serialIn`, shift-section stage 0 takes the top feedback-section stage, and every stage XORs in its own `dIn` bit.
- R9: `q[LR_LEN-1:0]` shows the feedback-section stages and `q[LR_LEN+SR_LEN-1:LR_LEN]` shows the shift-section stages, lowest index first. `serialOut` equals the top `q` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 11 load, 00 generate, 10 signature, 01 shift |
| dIn | input | LR_LEN+SR_LEN | Parallel data / signature inputs |
| serialIn | input | 1 | Serial input to feedback-section stage 0 |
| q | output | LR_LEN+SR_LEN | All stage values |
| serialOut | output | 1 | Top shift-section stage |

## Verification
The bench builds the block with a six-stage feedback section whose mask sets stages 0, 1 and 4, taps at 1, 3 and 5, and an eight-stage shift section. The truth table has three ones, so p is 3/8. The inversion mask sets stages 1, 3 and 6, which gives both p and 1-p stages along the chain. These values make the exact stage-by-stage model in every mode and the per-stage statistics both checkable in a short run. Because the feedback mask is asymmetric, a wrong tap, a swapped feedback source between generate and signature modes, or a missed inversion changes the expected values.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  typedef enum logic [1:0] {
    MODE_GEN   = 2'b00,
    MODE_SHIFT = 2'b01,
    MODE_SIG   = 2'b10,
    MODE_LOAD  = 2'b11
  } bpgMode_e;

  typedef struct packed {
    logic loadEn;
    logic genEn;
    logic sigEn;
    logic shiftEn;
    logic fbFromSr;  // feedback source: shift-section tail instead of LR tail
    logic srFromF;   // shift-section head takes the biasing function
    logic invEn;     // stage inversions active
  } bpgCtrl_t;

endpackage

// File: rtl/bpg_ctrl.sv
module bpg_ctrl
  import bpg_pkg::*;
(
  input  logic [1:0] mode,
  output bpgCtrl_t   ctrl
);

  bpgMode_e modeSel;
  assign modeSel = bpgMode_e'(mode);

  always_comb begin
    ctrl = '0;
    unique case (modeSel)
      MODE_LOAD:  ctrl.loadEn  = 1'b1;
      MODE_GEN:   begin
        ctrl.genEn = 1'b1;
        ctrl.invEn = 1'b1;
      end
      MODE_SIG:   ctrl.sigEn   = 1'b1;
      MODE_SHIFT: ctrl.shiftEn = 1'b1;
      default:    ctrl.loadEn  = 1'b1;
    endcase
    ctrl.fbFromSr = mode[1];
    ctrl.srFromF  = (mode[1] == mode[0]);
  end

endmodule

// File: rtl/bpg_lr_chain.sv
module bpg_lr_chain
  import bpg_pkg::*;
#(
  parameter int                LR_LEN  = 6,
  parameter logic [LR_LEN-1:0] FB_MASK = 6'b010011
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpgCtrl_t          ctrl,
  input  logic              serialIn,
  input  logic [LR_LEN-1:0] dIn,
  input  logic              srOut,
  output logic [LR_LEN-1:0] lrQ
);

  localparam int TOP = LR_LEN - 1;

  logic              lrOut;
  logic              fbBit;
  logic [LR_LEN-1:0] nxt;
  logic              unusedCtrl;

  assign lrOut      = lrQ[TOP];
  assign fbBit      = ctrl.fbFromSr ? srOut : lrOut;
  assign unusedCtrl = ^ctrl;

  for (genvar i = 0; i < LR_LEN; i++) begin : g_cell
    logic shiftIn;
    logic cellNxt;
    if (i == 0) begin : g_head
      assign shiftIn = serialIn;
    end else begin : g_body
      assign shiftIn = lrQ[i-1];
    end

    if (FB_MASK[i]) begin : g_fbCell
      always_comb begin
        if (ctrl.loadEn)       cellNxt = dIn[i];
        else if (ctrl.shiftEn) cellNxt = shiftIn;
        else if (ctrl.genEn)   cellNxt = shiftIn ^ fbBit;
        else                   cellNxt = shiftIn ^ fbBit ^ dIn[i];
      end
    end else begin : g_plainCell
      always_comb begin
        if (ctrl.loadEn)       cellNxt = dIn[i];
        else if (ctrl.shiftEn) cellNxt = shiftIn;
        else if (ctrl.genEn)   cellNxt = shiftIn;
        else                   cellNxt = shiftIn ^ dIn[i];
      end
    end
    assign nxt[i] = cellNxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lrQ <= '0;
    else       lrQ <= nxt;
  end

  // R2
  lr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadEn |=> lrQ == $past(dIn));

  // R3
  lr_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftEn |=> lrQ == {$past(lrQ[TOP-1:0]), $past(serialIn)});

  // R4
  lr_gen_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.genEn |=> lrQ[0] == ($past(serialIn) ^ $past(lrQ[TOP])));

  // R8
  lr_sig_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.sigEn |=> lrQ[0] == ($past(serialIn) ^ $past(srOut) ^ $past(dIn[0])));

endmodule

// File: rtl/bpg_sr_chain.sv
module bpg_sr_chain
  import bpg_pkg::*;
#(
  parameter int                LR_LEN   = 6,
  parameter int                SR_LEN   = 8,
  parameter int                TAP0     = 1,
  parameter int                TAP1     = 3,
  parameter int                TAP2     = 5,
  parameter logic [7:0]        F_TABLE  = 8'b0001_0110,
  parameter logic [SR_LEN-1:0] INV_MASK = 8'b0100_1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpgCtrl_t          ctrl,
  input  logic [LR_LEN-1:0] lrQ,
  input  logic [SR_LEN-1:0] dIn,
  output logic [SR_LEN-1:0] srQ
);

  localparam int TOP = SR_LEN - 1;

  logic [2:0]        fSel;
  logic              fOut;
  logic              headIn;
  logic              lrOut;
  logic [SR_LEN-1:0] nxt;
  logic              unusedCtrl;
  logic              unusedLr;

  assign lrOut      = lrQ[LR_LEN-1];
  assign fSel       = {lrQ[TAP2], lrQ[TAP1], lrQ[TAP0]};
  assign fOut       = F_TABLE[fSel];
  assign headIn     = ctrl.srFromF ? fOut : lrOut;
  assign unusedCtrl = ^ctrl;
  assign unusedLr   = ^lrQ;

  for (genvar j = 0; j < SR_LEN; j++) begin : g_cell
    logic shiftIn;
    logic cellNxt;
    if (j == 0) begin : g_head
      assign shiftIn = headIn;
    end else begin : g_body
      assign shiftIn = srQ[j-1];
    end

    if (INV_MASK[j]) begin : g_invCell
      always_comb begin
        if (ctrl.loadEn)       cellNxt = dIn[j];
        else if (ctrl.shiftEn) cellNxt = shiftIn;
        else if (ctrl.genEn)   cellNxt = shiftIn ^ ctrl.invEn;
        else                   cellNxt = shiftIn ^ dIn[j];
      end
    end else begin : g_plainCell
      always_comb begin
        if (ctrl.loadEn)       cellNxt = dIn[j];
        else if (ctrl.shiftEn) cellNxt = shiftIn;
        else if (ctrl.genEn)   cellNxt = shiftIn;
        else                   cellNxt = shiftIn ^ dIn[j];
      end
    end
    assign nxt[j] = cellNxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srQ <= '0;
    else       srQ <= nxt;
  end

  // R5
  sr_gen_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.genEn |=> srQ[0] == (F_TABLE[$past(fSel)] ^ INV_MASK[0]));

  // R6
  sr_gen_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.genEn |=> srQ[TOP] == ($past(srQ[TOP-1]) ^ INV_MASK[TOP]));

  // R8
  sr_sig_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.sigEn |=> srQ[0] == ($past(lrOut) ^ $past(dIn[0])));

  // R3
  sr_shift_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftEn |=> srQ[0] == $past(lrOut));

endmodule

// File: rtl/biased_pattern_reg.sv
module biased_pattern_reg
  import bpg_pkg::*;
#(
  parameter int                LR_LEN   = 6,
  parameter int                SR_LEN   = 8,
  parameter logic [LR_LEN-1:0] FB_MASK  = 6'b010011,
  parameter int                TAP0     = 1,
  parameter int                TAP1     = 3,
  parameter int                TAP2     = 5,
  parameter logic [7:0]        F_TABLE  = 8'b0001_0110,
  parameter logic [SR_LEN-1:0] INV_MASK = 8'b0100_1010,
  localparam int               WIDTH    = LR_LEN + SR_LEN
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] dIn,
  input  logic             serialIn,
  output logic [WIDTH-1:0] q,
  output logic             serialOut
);

  bpgCtrl_t          ctrl;
  logic [LR_LEN-1:0] lrQ;
  logic [SR_LEN-1:0] srQ;

  bpg_ctrl u_ctrl (
    .mode (mode),
    .ctrl (ctrl)
  );

  bpg_lr_chain #(
    .LR_LEN  (LR_LEN),
    .FB_MASK (FB_MASK)
  ) u_lr (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .serialIn (serialIn),
    .dIn      (dIn[LR_LEN-1:0]),
    .srOut    (srQ[SR_LEN-1]),
    .lrQ      (lrQ)
  );

  bpg_sr_chain #(
    .LR_LEN   (LR_LEN),
    .SR_LEN   (SR_LEN),
    .TAP0     (TAP0),
    .TAP1     (TAP1),
    .TAP2     (TAP2),
    .F_TABLE  (F_TABLE),
    .INV_MASK (INV_MASK)
  ) u_sr (
    .clk  (clk),
    .rstN (rstN),
    .ctrl (ctrl),
    .lrQ  (lrQ),
    .dIn  (dIn[WIDTH-1:LR_LEN]),
    .srQ  (srQ)
  );

  assign q         = {srQ, lrQ};
  assign serialOut = srQ[SR_LEN-1];

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |-> q == '0);

endmodule

// File: tb/biased_pattern_reg_tb_top.sv
module biased_pattern_reg_tb_top;

  localparam int          LR   = 6;
  localparam int          SR   = 8;
  localparam int          N    = LR + SR;
  localparam logic [LR-1:0] FBM = 6'b010011;
  localparam int          T0   = 1;
  localparam int          T1   = 3;
  localparam int          T2   = 5;
  localparam logic [7:0]  FT   = 8'b0001_0110;
  localparam logic [SR-1:0] INV = 8'b0100_1010;
  localparam int          STAT_N = 16000;

  logic         clk = 1'b0;
  logic         rstN = 1'b1;
  logic [1:0]   mode = 2'b11;
  logic [N-1:0] dIn = '0;
  logic         serialIn = 1'b0;
  logic [N-1:0] q;
  logic         serialOut;

  int compared = 0;
  int mismatched = 0;
  int ones [SR];

  typedef struct {
    logic [N-1:0] q;
    string        tag;
  } exp_t;
  exp_t expQ[$];

  logic [N-1:0] mState = '0;
  logic [30:0]  rng = 31'h1;

  biased_pattern_reg #(
    .LR_LEN(LR), .SR_LEN(SR), .FB_MASK(FBM),
    .TAP0(T0), .TAP1(T1), .TAP2(T2), .F_TABLE(FT), .INV_MASK(INV)
  ) dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .dIn(dIn),
    .serialIn(serialIn), .q(q), .serialOut(serialOut)
  );

  always #2 clk = ~clk;

  function automatic logic [N-1:0] refNext(logic [N-1:0] st, logic [1:0] md,
                                           logic [N-1:0] d, logic si);
    logic [LR-1:0] l;
    logic [SR-1:0] s;
    logic [LR-1:0] nl;
    logic [SR-1:0] ns;
    logic fb;
    logic prev;
    logic f;
    l = st[LR-1:0];
    s = st[N-1:LR];
    nl = '0;
    ns = '0;
    if (md == 2'b11) return d;
    fb = (md[1]) ? s[SR-1] : l[LR-1];
    f  = FT[{l[T2], l[T1], l[T0]}];
    for (int i = 0; i < LR; i++) begin
      prev = (i == 0) ? si : l[(i == 0) ? 0 : i-1];
      if (md == 2'b01)      nl[i] = prev;
      else if (md == 2'b00) nl[i] = prev ^ (FBM[i] & fb);
      else                  nl[i] = prev ^ (FBM[i] & fb) ^ d[i];
    end
    for (int j = 0; j < SR; j++) begin
      if (j == 0) prev = (md == 2'b00) ? f : l[LR-1];
      else        prev = s[j-1];
      if (md == 2'b01)      ns[j] = prev;
      else if (md == 2'b00) ns[j] = prev ^ INV[j];
      else                  ns[j] = prev ^ d[LR+j];
    end
    return {ns, nl};
  endfunction

  function automatic logic rngBit();
    logic nb;
    nb  = rng[30] ^ rng[27];
    rng = {rng[29:0], nb};
    return nb;
  endfunction

  task automatic step(input logic [1:0] md, input logic [N-1:0] d,
                      input logic si, input string tag);
    @(negedge clk);
    mode     = md;
    dIn      = d;
    serialIn = si;
    mState   = refNext(mState, md, d, si);
    expQ.push_back('{mState, tag});
  endtask

  // monitor: compares each expected item one time unit after the edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      compared++;
      if (q !== e.q || serialOut !== e.q[N-1]) begin
        mismatched++;
        $display("FAIL %s: q=%h serialOut=%b expected q=%h serialOut=%b",
                 e.tag, q, serialOut, e.q, e.q[N-1]);
      end
      if (e.tag == "R7")
        for (int j = 0; j < SR; j++) ones[j] += int'(q[LR+j]);
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    summary();
  end

  initial begin
    logic pol;
    int   pc;
    real  expFrac;
    real  frac;
    for (int j = 0; j < SR; j++) ones[j] = 0;

    // R1: reset clears every stage
    #1 rstN = 1'b0;
    #4;
    compared++;
    if (q !== '0 || serialOut !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: q=%h serialOut=%b expected q=0 serialOut=0", q, serialOut);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R2 / R9: parallel loads
    step(2'b11, 14'h2A5C, 1'b0, "R2");
    step(2'b11, 14'h3FFF, 1'b1, "R2");
    step(2'b11, 14'h0000, 1'b0, "R2");
    step(2'b11, 14'h1234, 1'b1, "R9");

    // R3 / R9: serial shift through both sections
    for (int k = 0; k < 20; k++) step(2'b01, 14'h3FFF, k[0] ^ k[2], "R3");
    step(2'b11, 14'h2001, 1'b0, "R9");
    for (int k = 0; k < 3; k++) step(2'b01, '0, 1'b0, "R9");

    // R8: signature compression with changing inputs
    step(2'b11, 14'h15A3, 1'b0, "R8");
    for (int k = 0; k < 40; k++) step(2'b10, N'(k * 14'h0B57 + 14'h0321), k[1], "R8");
    for (int k = 0; k < 10; k++) step(2'b10, '0, 1'b0, "R8");

    // R4 / R5 / R6: exact generation sequence
    step(2'b11, 14'h0000, 1'b0, "R4");
    for (int k = 0; k < 30; k++) step(2'b00, 14'h3FFF, rngBit(), "R4");
    for (int k = 0; k < 30; k++) step(2'b00, 14'h1555, rngBit(), "R5");
    for (int k = 0; k < 30; k++) step(2'b00, 14'h0AAA, rngBit(), "R6");

    // R7: statistics under a random serial stream
    for (int k = 0; k < STAT_N; k++) step(2'b00, '0, rngBit(), "R7");
    repeat (3) @(negedge clk);

    pc = 0;
    for (int b = 0; b < 8; b++) pc += int'(FT[b]);
    pol = 1'b0;
    for (int j = 0; j < SR; j++) begin
      pol     = pol ^ INV[j];
      expFrac = pol ? (8.0 - pc) / 8.0 : pc / 8.0;
      frac    = real'(ones[j]) / STAT_N;
      compared++;
      if (frac < expFrac - 0.03 || frac > expFrac + 0.03) begin
        mismatched++;
        $display("FAIL R7: stage %0d ones fraction=%f expected=%f", j, frac, expFrac);
      end
    end

    summary();
  end

endmodule